// File: doc/BRIEF.md
# Binary Tree Route Computation Unit

This unit makes the forwarding decision for one node of a complete binary tree network. Each node is named by a heap-numbered label: the root is 1, and a node x has children 2x (left) and 2x+1 (right). A label therefore carries a leading one, and its bit count equals the node's level, with the root at level 1. Given the label of the node doing the routing and the destination label of a packet, the unit picks one of four output directions. These are toward the parent, toward the left child, toward the right child, or delivery at this node. It also reports how many levels the packet still has to climb before it reaches the lowest common ancestor of the two labels.

The decision is made from label arithmetic alone. The lowest common ancestor is the longest shared leading bit string of the two labels. The current node is an ancestor of the destination exactly when its whole label is that shared string. When it is an ancestor, the destination bit that follows the current node's bits names the child to take.

Requests enter on a valid/ready interface and results leave on a second valid/ready interface. A request transfers on a clock edge where in_valid and in_ready are both high. A result transfers on an edge where out_valid and out_ready are both high. While out_valid is high and out_ready is low, the result is held unchanged. With the default registered build, in_ready is high whenever the output register is empty or is being drained in the same cycle. A combinational build passes valid forward and ready back unchanged.

Top module: `tree_route_unit`

## Requirements
- R1: out_port is one-hot with bit 0 = parent, bit 1 = left child, bit 2 = right child, bit 3 = deliver here; at most one bit is set, and exactly one is set whenever out_err is low.
- R2: When the current label's bits are not a leading part of the destination label (the destination is an ancestor of the current node or lies in another subtree), out_port selects the parent (bit 0).
- R3: When the current and destination labels are equal and non-zero, out_port selects local delivery (bit 3) and out_climb is 0.
- R4: When the current node is a proper ancestor of the destination, the destination bit at position (destination level − current level − 1), counted from bit 0, selects the left child (0, out_port bit 1) or the right child (1, out_port bit 2), and out_climb is 0.
- R5: out_climb equals the current node's level minus the length of the longest common leading bit string of the two labels, where a node's level is the position of its highest set bit plus one.
- R6: If either label is zero, out_err is 1, out_port is 0 and out_climb is 0; otherwise out_err is 0.
- R7: Labels using the full DEPTH bits (highest bit set) are routed correctly in every direction, including between the root and the deepest level.
- R8: While out_valid is high and out_ready is low, out_valid, out_port, out_climb and out_err keep their values into the next cycle.
- R9: After reset out_valid is 0; in the registered build in_ready is 1 whenever out_valid is 0 or out_ready is 1.
- R10: In the registered build every accepted request yields exactly one result, one cycle after acceptance when the output is free, and results leave in the order requests were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| cur_label | input | DEPTH | Heap label of the routing node |
| dst_label | input | DEPTH | Heap label of the packet's destination |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_port | output | 4 | One-hot direction: parent, left, right, local |
| out_climb | output | $clog2(DEPTH+1) | Levels to climb to the lowest common ancestor |
| out_err | output | 1 | A zero label was presented |

## Verification
The bench targets labels whose lengths differ widely. These include the root against the deepest labels, labels with the top bit set, and siblings and cousins whose only shared bit is the leading one. A design that mis-encoded the leading one would report the wrong level there. It would then pick the wrong child bit or return an off-by-one climb count. Pairs where the destination is an ancestor of the current node check that such a case goes up and is not mistaken for a descent. Zero labels on either side check that no direction leaks out alongside the error. Random back-pressure on out_ready exposes a result that changes while stalled, or a request dropped or duplicated when the output register is full.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;
  localparam int PORT_W = 4;
  localparam int P_UP    = 0;
  localparam int P_LEFT  = 1;
  localparam int P_RIGHT = 2;
  localparam int P_LOCAL = 3;

  typedef logic [PORT_W-1:0] port_vec_t;
endpackage

// File: rtl/tr_level_enc.sv
module tr_level_enc #(
  parameter int LW  = 8,
  parameter int LVW = $clog2(LW + 1)
) (
  input  logic [LW-1:0]  label,
  output logic [LVW-1:0] level
);
  // Highest set bit wins: the last assignment in ascending order sticks.
  always_comb begin
    level = '0;
    for (int i = 0; i < LW; i++) begin
      if (label[i]) level = LVW'(i + 1);
    end
  end
endmodule

// File: rtl/tr_prefix_len.sv
module tr_prefix_len #(
  parameter int LW  = 8,
  parameter int LVW = $clog2(LW + 1)
) (
  input  logic [LW-1:0]  a_label,
  input  logic [LW-1:0]  b_label,
  input  logic [LVW-1:0] a_level,
  input  logic [LVW-1:0] b_level,
  output logic [LVW-1:0] common_len
);
  logic [LW-1:0] a_head [LW];
  logic [LW-1:0] b_head [LW];
  logic [LW-1:0] hit;

  // Leading k bits of each label; matches nest, so the longest hit wins.
  for (genvar k = 1; k <= LW; k++) begin : g_len
    always_comb begin
      a_head[k-1] = a_label >> (a_level - LVW'(k));
      b_head[k-1] = b_label >> (b_level - LVW'(k));
      hit[k-1]    = (LVW'(k) <= a_level) && (LVW'(k) <= b_level) &&
                    (a_head[k-1] == b_head[k-1]);
    end
  end

  always_comb begin
    common_len = '0;
    for (int k = 1; k <= LW; k++) begin
      if (hit[k-1]) common_len = LVW'(k);
    end
  end
endmodule

// File: rtl/tr_route_core.sv
module tr_route_core
  import tree_route_pkg::*;
#(
  parameter int LW  = 8,
  parameter int LVW = $clog2(LW + 1)
) (
  input  logic [LW-1:0]  cur_label,
  input  logic [LW-1:0]  dst_label,
  output port_vec_t      port,
  output logic [LVW-1:0] climb,
  output logic           err
);
  logic [LVW-1:0] cur_lvl, dst_lvl, shared;
  logic [LW-1:0]  dst_tail;
  logic           bad, below;

  tr_level_enc #(.LW(LW), .LVW(LVW)) u_cur_lvl (.label(cur_label), .level(cur_lvl));
  tr_level_enc #(.LW(LW), .LVW(LVW)) u_dst_lvl (.label(dst_label), .level(dst_lvl));

  tr_prefix_len #(.LW(LW), .LVW(LVW)) u_common (
    .a_label   (cur_label),
    .b_label   (dst_label),
    .a_level   (cur_lvl),
    .b_level   (dst_lvl),
    .common_len(shared)
  );

  always_comb begin
    bad      = (cur_label == '0) || (dst_label == '0);
    below    = (shared == cur_lvl);
    dst_tail = dst_label >> (dst_lvl - cur_lvl - LVW'(1));
    port     = '0;
    climb    = '0;
    err      = bad;
    if (!bad) begin
      climb = cur_lvl - shared;
      if (!below)                    port[P_UP]    = 1'b1;
      else if (cur_label == dst_label) port[P_LOCAL] = 1'b1;
      else if (dst_tail[0])          port[P_RIGHT] = 1'b1;
      else                           port[P_LEFT]  = 1'b1;
    end
  end
endmodule

// File: rtl/tree_route_unit.sv
module tree_route_unit
  import tree_route_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter bit REGISTERED = 1'b1,
  localparam int LVW       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DEPTH-1:0] cur_label,
  input  logic [DEPTH-1:0] dst_label,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [3:0]       out_port,
  output logic [LVW-1:0]   out_climb,
  output logic             out_err
);
  port_vec_t      c_port;
  logic [LVW-1:0] c_climb;
  logic           c_err;

  tr_route_core #(.LW(DEPTH), .LVW(LVW)) u_core (
    .cur_label(cur_label),
    .dst_label(dst_label),
    .port     (c_port),
    .climb    (c_climb),
    .err      (c_err)
  );

  if (REGISTERED) begin : g_reg
    logic           v_q;
    port_vec_t      port_q;
    logic [LVW-1:0] climb_q;
    logic           err_q;

    assign in_ready = !v_q || out_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q     <= 1'b0;
        port_q  <= '0;
        climb_q <= '0;
        err_q   <= 1'b0;
      end else if (in_ready) begin
        v_q <= in_valid;
        if (in_valid) begin
          port_q  <= c_port;
          climb_q <= c_climb;
          err_q   <= c_err;
        end
      end
    end

    assign out_valid = v_q;
    assign out_port  = port_q;
    assign out_climb = climb_q;
    assign out_err   = err_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_port  = c_port;
    assign out_climb = c_climb;
    assign out_err   = c_err;
  end
endmodule

// File: rtl/tree_route_unit_chk.sv
module tree_route_unit_chk #(
  parameter int DEPTH      = 8,
  parameter bit REGISTERED = 1'b1,
  localparam int LVW       = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [3:0]     out_port,
  input logic [LVW-1:0] out_climb,
  input logic           out_err
);
  // R1
  port_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($onehot0(out_port) && (out_err || $countones(out_port) == 1)));

  // R6
  err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_port == 4'b0 && out_climb == '0));

  // R3
  local_no_climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_port[3]) |-> (out_climb == '0));

  // R4
  descend_no_climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_port[1] || out_port[2])) |-> (out_climb == '0));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_port) &&
                                   $stable(out_climb) && $stable(out_err)));

  if (REGISTERED) begin : g_reg_chk
    // R9
    ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid || out_ready) |-> in_ready);

    // R10
    accept_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
  end
endmodule

bind tree_route_unit tree_route_unit_chk #(.DEPTH(DEPTH), .REGISTERED(REGISTERED)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_port (out_port),
  .out_climb(out_climb),
  .out_err  (out_err)
);

// File: tb/tree_route_unit_test.sv
`timescale 1ns/1ps
module tree_route_unit_test;
  localparam int DEPTH = 8;
  localparam int LVW   = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [DEPTH-1:0] cur_label = '0;
  logic [DEPTH-1:0] dst_label = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [3:0]       out_port;
  logic [LVW-1:0]   out_climb;
  logic             out_err;

  int total = 0;
  int bad   = 0;
  bit stress = 1'b0;

  typedef struct {
    logic [3:0] port;
    int         climb;
    logic       err;
    string      tag;
    int         c;
    int         d;
  } exp_t;

  exp_t expq[$];

  tree_route_unit #(.DEPTH(DEPTH), .REGISTERED(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .cur_label(cur_label), .dst_label(dst_label), .out_valid(out_valid),
    .out_ready(out_ready), .out_port(out_port), .out_climb(out_climb),
    .out_err(out_err)
  );

  always #2.5 clk = ~clk;

  function automatic int bits_of(int x);
    int n = 0;
    while (x != 0) begin
      n++;
      x = x >> 1;
    end
    return n;
  endfunction

  // Independent model: trim the longer label, then walk both up to a meeting point.
  function automatic exp_t model(int c, int d, string tag);
    exp_t e;
    int a, b, la, lb, lc, ld;
    e.tag = tag; e.c = c; e.d = d;
    e.port = 4'b0; e.climb = 0; e.err = 1'b0;
    if (c == 0 || d == 0) begin
      e.err = 1'b1;
      return e;
    end
    a = c; b = d; lc = bits_of(c); ld = bits_of(d); la = lc; lb = ld;
    while (la > lb) begin a = a >> 1; la--; end
    while (lb > la) begin b = b >> 1; lb--; end
    while (a != b) begin a = a >> 1; b = b >> 1; la--; end
    e.climb = lc - la;
    if (la < lc)      e.port = 4'b0001;
    else if (c == d)  e.port = 4'b1000;
    else if (((d >> (ld - lc - 1)) & 1) != 0) e.port = 4'b0100;
    else              e.port = 4'b0010;
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic send(int c, int d, string tag);
    @(negedge clk);
    cur_label = DEPTH'(c);
    dst_label = DEPTH'(d);
    in_valid  = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    expq.push_back(model(c, d, tag));
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Consumer ready pattern, changed just after each edge.
  always @(posedge clk) begin
    #1 out_ready = stress ? (($urandom % 3) != 0) : 1'b1;
  end

  // Monitor: compares results that transfer at the coming edge; tracks stalls.
  logic [3:0]     held_port;
  int             held_climb;
  logic           held_err;
  bit             was_stalled = 1'b0;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (was_stalled) begin
        check(out_valid && out_port == held_port && int'(out_climb) == held_climb &&
              out_err == held_err, "R8", "stalled result changed",
              int'(out_port), int'(held_port));
      end
      was_stalled = out_valid && !out_ready;
      held_port = out_port; held_climb = int'(out_climb); held_err = out_err;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R10", "unexpected result, count", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(out_port == e.port, e.tag, $sformatf("port c=%0d d=%0d", e.c, e.d),
                int'(out_port), int'(e.port));
          check(int'(out_climb) == e.climb, e.tag, $sformatf("climb c=%0d d=%0d", e.c, e.d),
                int'(out_climb), e.climb);
          check(out_err == e.err, e.tag, $sformatf("err c=%0d d=%0d", e.c, e.d),
                int'(out_err), int'(e.err));
        end
      end
    end
  end

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R9 reset state
    check(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9", "in_ready when empty", int'(in_ready), 1);

    send(1, 1, "R3");     send(37, 37, "R3");
    send(1, 2, "R4");     send(1, 3, "R4");
    send(2, 5, "R4");     send(2, 4, "R4");
    send(5, 2, "R2");     send(9, 1, "R2");
    send(4, 7, "R5");     send(12, 14, "R5");
    send(0, 3, "R6");     send(3, 0, "R6");     send(0, 0, "R6");
    send(255, 128, "R7"); send(128, 255, "R7");
    send(1, 255, "R7");   send(1, 128, "R7");
    send(64, 129, "R7");  send(255, 1, "R7");

    // R1 R5 R10: random pairs, first with a free output then with back-pressure
    for (int i = 0; i < 60; i++) send($urandom % 256, $urandom % 256, "R1");
    stress = 1'b1;
    for (int i = 0; i < 120; i++) send($urandom % 256, $urandom % 256, "R10");
    stress = 1'b0;

    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R10", "results missing", expq.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired, cycles", 150000, 0);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule